// File: doc/BRIEF.md
# Four-Phase LCD Multiplex Sequencer

This block times a quarter-duty, third-bias liquid crystal display. It runs off a free-running oscillator clock and steps through eight half-periods per frame: each of the four backplanes owns two consecutive half-periods. During a backplane's turn, the matching 32-bit slice of a 128-bit segment image drives the frontplanes. Every plane output is a 2-bit drive-level code. External analog drivers turn these codes into the voltages 0, one third, two thirds and full.

The segment image is taken from the `segLatch` input only when one frame ends and the next begins. Every backplane phase in a frame therefore shows the same data. A `boost` output requests extra drive current for the first few oscillator cycles after every backplane level change, so that the panel capacitance charges quickly. Level codes are 00 for ground, 01 for one third, 10 for two thirds and 11 for full.

Top module: `lcd_quad_sequencer`

## Requirements
- R1: In the first cycle after reset is released, the first backplane is at code 11, the other three backplanes are at 01, every frontplane is at 10, and `boost` is 1.
- R2: Exactly one backplane is active at any time. Backplanes take turns in ascending order (field 0 = bits [1:0] of `bpLevel`, then fields 1, 2 and 3) and wrap back to field 0. Each turn lasts 2*HALF_CYCLES clock cycles.
- R3: The active backplane shows code 11 during the first half of its turn (HALF_CYCLES cycles) and code 00 during the second half.
- R4: Each inactive backplane shows code 01 during the first half of the current turn and code 10 during the second half.
- R5: A frontplane whose selected data bit is 1 shows code 00 in the first half and code 11 in the second half.
- R6: A frontplane whose selected data bit is 0 shows code 10 in the first half and code 01 in the second half.
- R7: While backplane field k is active, frontplane field j (bits [2j+1:2j] of `fpLevel`) takes its data from bit 32k+j of the frame's segment image.
- R8: `boost` is 1 for the first BOOST_CYCLES cycles of every half-period, the cycle after reset included, and 0 for the rest of the half-period. Backplane codes never change while `boost` is 0.
- R9: A frame lasts 8*HALF_CYCLES cycles. The segment image is sampled from `segLatch` at the clock edge that ends a frame. Changes to `segLatch` at any other time have no effect on `fpLevel` until the next frame.
- R10: During the first frame after reset, the segment image is all zeros, whatever value `segLatch` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| segLatch | input | 128 | Latched segment data, 32 bits per backplane |
| bpLevel | output | 8 | Four 2-bit backplane level codes |
| fpLevel | output | 64 | Thirty-two 2-bit frontplane level codes |
| boost | output | 1 | High-current drive request |

## Verification
A wrong half-period counter shows up on `bpLevel` and `boost` together: a stretched or shortened half moves the next level change and its boost pulse, and the error is visible at the first boundary after the fault. A wrong phase index lights the wrong backplane, or selects a data slice that does not match the active backplane, so `fpLevel` differs from the model within the same half-period. A snapshot loaded at the wrong moment appears only when `segLatch` changes in the middle of a frame, so the stimulus changes it at random points and also right at the frame edge.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  // Number of backplanes (multiplex ratio).
  localparam int BP_COUNT = 4;
  localparam int PHASE_W  = $clog2(BP_COUNT);

  // Drive-level codes handed to the analog plane drivers.
  typedef enum logic [1:0] {
    LVL_GND        = 2'b00,
    LVL_THIRD      = 2'b01,
    LVL_TWO_THIRDS = 2'b10,
    LVL_FULL       = 2'b11
  } drive_lvl_e;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic               loadSnap;   // capture a new segment image at this edge
    logic [PHASE_W-1:0] phase;      // index of the active backplane
    logic               secondHalf; // second half of the active turn
  } seq_strobe_t;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int HALF_CYCLES  = 125,
  parameter int BOOST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  output seq_strobe_t strobe,
  output logic        boost
);
  localparam int HALVES  = 2 * BP_COUNT;
  localparam int CNT_W   = $clog2(HALF_CYCLES);
  localparam int IDX_W   = $clog2(HALVES);
  localparam int BOOST_W = $clog2(BOOST_CYCLES + 1);

  logic [CNT_W-1:0]   halfCnt;
  logic [IDX_W-1:0]   halfIdx;
  logic [BOOST_W-1:0] boostCnt;
  logic               halfEnd;
  logic               frameEnd;

  assign halfEnd  = (halfCnt == CNT_W'(HALF_CYCLES - 1));
  assign frameEnd = halfEnd && (halfIdx == IDX_W'(HALVES - 1));

  // Cycle counter within a half-period, and half-period index within a frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      halfIdx <= '0;
    end else if (halfEnd) begin
      halfCnt <= '0;
      halfIdx <= frameEnd ? '0 : halfIdx + 1'b1;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // Boost down-counter: reloaded whenever the backplane levels move.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boostCnt <= BOOST_W'(BOOST_CYCLES);
    end else if (halfEnd) begin
      boostCnt <= BOOST_W'(BOOST_CYCLES);
    end else if (boostCnt != '0) begin
      boostCnt <= boostCnt - 1'b1;
    end
  end

  assign boost             = (boostCnt != '0);
  assign strobe.loadSnap   = frameEnd;
  assign strobe.phase      = halfIdx[IDX_W-1:1];
  assign strobe.secondHalf = halfIdx[0];
endmodule

// File: rtl/lcd_seq_datapath.sv
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int FP_COUNT = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seq_strobe_t                  strobe,
  input  logic [BP_COUNT*FP_COUNT-1:0] segLatch,
  output logic [2*BP_COUNT-1:0]        bpLevel,
  output logic [2*FP_COUNT-1:0]        fpLevel
);
  localparam int IMG_W = BP_COUNT * FP_COUNT;

  logic [IMG_W-1:0]    segSnap;
  logic [FP_COUNT-1:0] activeBlock;

  // Frame-aligned snapshot of the segment image.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segSnap <= '0;
    end else if (strobe.loadSnap) begin
      segSnap <= segLatch;
    end
  end

  assign activeBlock = segSnap[strobe.phase * FP_COUNT +: FP_COUNT];

  // Backplane codes.
  for (genvar i = 0; i < BP_COUNT; i++) begin : g_bp
    drive_lvl_e bpCode;
    always_comb begin
      if (strobe.phase == PHASE_W'(i)) begin
        bpCode = strobe.secondHalf ? LVL_GND : LVL_FULL;
      end else begin
        bpCode = strobe.secondHalf ? LVL_TWO_THIRDS : LVL_THIRD;
      end
    end
    assign bpLevel[2*i +: 2] = bpCode;
  end

  // Frontplane codes.
  for (genvar j = 0; j < FP_COUNT; j++) begin : g_fp
    drive_lvl_e fpCode;
    always_comb begin
      if (activeBlock[j]) begin
        fpCode = strobe.secondHalf ? LVL_FULL : LVL_GND;
      end else begin
        fpCode = strobe.secondHalf ? LVL_THIRD : LVL_TWO_THIRDS;
      end
    end
    assign fpLevel[2*j +: 2] = fpCode;
  end
endmodule

// File: rtl/lcd_quad_sequencer.sv
module lcd_quad_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int FP_COUNT     = 32,
  parameter int HALF_CYCLES  = 125,
  parameter int BOOST_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [BP_COUNT*FP_COUNT-1:0] segLatch,
  output logic [2*BP_COUNT-1:0]        bpLevel,
  output logic [2*FP_COUNT-1:0]        fpLevel,
  output logic                         boost
);
  seq_strobe_t strobe;

  lcd_seq_ctrl #(
    .HALF_CYCLES (HALF_CYCLES),
    .BOOST_CYCLES(BOOST_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .boost (boost)
  );

  lcd_seq_datapath #(
    .FP_COUNT(FP_COUNT)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .segLatch(segLatch),
    .bpLevel (bpLevel),
    .fpLevel (fpLevel)
  );
endmodule

// File: rtl/lcd_quad_sequencer_checker.sv
module lcd_quad_sequencer_checker
  import lcd_seq_pkg::*;
#(
  parameter int FP_COUNT     = 32,
  parameter int BOOST_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2*BP_COUNT-1:0] bpLevel,
  input logic [2*FP_COUNT-1:0] fpLevel,
  input logic                  boost
);
  localparam int RUN_W = $clog2(BOOST_CYCLES + 2);

  logic [BP_COUNT-1:0] bpExtreme;
  logic [PHASE_W-1:0]  activeIdx;
  logic                anyFull, anyGnd, bpFirstCodes, bpSecondCodes;
  logic                fpLowAllZero, fpLowAllOne;
  logic [RUN_W-1:0]    boostRun;

  always_comb begin
    activeIdx     = '0;
    anyFull       = 1'b0;
    anyGnd        = 1'b0;
    bpFirstCodes  = 1'b1;
    bpSecondCodes = 1'b1;
    for (int i = 0; i < BP_COUNT; i++) begin
      bpExtreme[i] = (bpLevel[2*i +: 2] == 2'b11) || (bpLevel[2*i +: 2] == 2'b00);
      if (bpExtreme[i]) activeIdx = PHASE_W'(i);
      if (bpLevel[2*i +: 2] == 2'b11) anyFull = 1'b1;
      if (bpLevel[2*i +: 2] == 2'b00) anyGnd = 1'b1;
      if (!(bpLevel[2*i +: 2] == 2'b11 || bpLevel[2*i +: 2] == 2'b01)) bpFirstCodes = 1'b0;
      if (!(bpLevel[2*i +: 2] == 2'b00 || bpLevel[2*i +: 2] == 2'b10)) bpSecondCodes = 1'b0;
    end
    fpLowAllZero = 1'b1;
    fpLowAllOne  = 1'b1;
    for (int j = 0; j < FP_COUNT; j++) begin
      if (fpLevel[2*j]) fpLowAllZero = 1'b0;
      else fpLowAllOne = 1'b0;
    end
  end

  // Length of the current run of boost cycles, before this cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) boostRun <= '0;
    else if (boost) boostRun <= boostRun + 1'b1;
    else boostRun <= '0;
  end

  assert_single_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(bpExtreme));

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (activeIdx != $past(activeIdx)) |->
      (activeIdx == PHASE_W'((int'($past(activeIdx)) + 1) % BP_COUNT)));

  assert_first_half_codes_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyFull |-> bpFirstCodes);

  assert_second_half_codes_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyGnd |-> bpSecondCodes);

  assert_fp_first_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    anyFull |-> fpLowAllZero);

  assert_fp_second_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyGnd |-> fpLowAllOne);

  assert_quiet_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !boost |-> $stable(bpLevel));

  assert_boost_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    boost |-> (boostRun < RUN_W'(BOOST_CYCLES)));

  assert_boost_full_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(boost) |-> (boostRun == RUN_W'(BOOST_CYCLES)));
endmodule

bind lcd_quad_sequencer lcd_quad_sequencer_checker #(
  .FP_COUNT    (FP_COUNT),
  .BOOST_CYCLES(BOOST_CYCLES)
) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .bpLevel(bpLevel),
  .fpLevel(fpLevel),
  .boost  (boost)
);

// File: tb/tb_lcd_quad_sequencer.sv
module tb_lcd_quad_sequencer;
  import lcd_seq_pkg::*;

  localparam int FP    = 32;
  localparam int HALF  = 125;
  localparam int BST   = 4;
  localparam int FRAME = 2 * BP_COUNT * HALF;
  localparam int IMG   = BP_COUNT * FP;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [IMG-1:0]    segLatch = '0;
  logic [2*BP_COUNT-1:0] bpLevel;
  logic [2*FP-1:0]   fpLevel;
  logic              boost;

  int vectors = 0;
  int fails   = 0;
  int t       = 0;
  bit done    = 1'b0;
  logic [IMG-1:0] modelSnap = '0;

  always #4 clk = ~clk;

  lcd_quad_sequencer #(.FP_COUNT(FP), .HALF_CYCLES(HALF), .BOOST_CYCLES(BST)) dut (
    .clk(clk), .rstN(rstN), .segLatch(segLatch),
    .bpLevel(bpLevel), .fpLevel(fpLevel), .boost(boost)
  );

  function automatic logic [2*BP_COUNT-1:0] expBp(int tt);
    int half = (tt / HALF) % (2 * BP_COUNT);
    int ph = half / 2;
    bit sec = (half % 2) == 1;
    logic [2*BP_COUNT-1:0] r;
    for (int i = 0; i < BP_COUNT; i++)
      r[2*i +: 2] = (i == ph) ? (sec ? 2'b00 : 2'b11) : (sec ? 2'b10 : 2'b01);
    return r;
  endfunction

  function automatic logic [2*FP-1:0] expFp(int tt, logic [IMG-1:0] snap);
    int half = (tt / HALF) % (2 * BP_COUNT);
    int ph = half / 2;
    bit sec = (half % 2) == 1;
    logic [2*FP-1:0] r;
    for (int j = 0; j < FP; j++)
      r[2*j +: 2] = snap[ph*FP + j] ? (sec ? 2'b11 : 2'b00) : (sec ? 2'b01 : 2'b10);
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
    end
  endtask

  task automatic checkCycle();
    check("R2 R3 R4 bpLevel", 64'(bpLevel), 64'(expBp(t)));
    if (t < FRAME) check("R10 fpLevel", fpLevel, expFp(t, '0));
    else check("R5 R6 R7 R9 fpLevel", fpLevel, expFp(t, modelSnap));
    check("R8 boost", 64'(boost), 64'((t % HALF) < BST));
  endtask

  function automatic logic [IMG-1:0] randImg();
    logic [IMG-1:0] r;
    for (int k = 0; k < IMG / 32; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  // mode 0: hold, 1: sparse random changes, 2: change every cycle,
  // 3: change only in the last cycle of each frame
  task automatic runCycles(int n, int mode);
    for (int k = 0; k < n; k++) begin
      checkCycle();
      if (mode == 1 && ($urandom % 40) == 0) segLatch = randImg();
      if (mode == 2) segLatch = randImg();
      if (mode == 3 && (t % FRAME) == FRAME - 1) segLatch = randImg();
      if ((t % FRAME) == FRAME - 1) modelSnap = segLatch;
      t++;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t = 0;
    modelSnap = '0;
  endtask

  task automatic checkResetState();
    // R1: first backplane full, others at one third, frontplanes at two thirds
    check("R1 bpLevel", 64'(bpLevel), 64'(8'b01_01_01_11));
    check("R1 fpLevel", fpLevel, {FP{2'b10}});
    check("R1 boost", 64'(boost), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    segLatch = {IMG{1'b1}};
    @(negedge clk);
    doReset();
    checkResetState();
    // R10: all-ones latch is not shown during the first frame
    runCycles(FRAME + 10, 0);
    // R7: walking pattern, one bit per block at distinct positions
    segLatch = '0;
    for (int k = 0; k < BP_COUNT; k++) segLatch[k*FP + (k*7 + 3) % FP] = 1'b1;
    runCycles(FRAME, 0);
    // R9: changes mid-frame and every cycle must wait for the frame edge
    runCycles(2 * FRAME, 1);
    runCycles(FRAME, 2);
    runCycles(2 * FRAME, 3);
    // R1 R10: reset in the middle of a frame with a nonzero latch
    runCycles(333, 1);
    segLatch = randImg();
    doReset();
    checkResetState();
    runCycles(2 * FRAME + 5, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog t=%0d actual=hung expected=done", t);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule